// File: doc/BRIEF.md
# Adaptive Binary Range Decoder

This block is the arithmetic core of a compressed-stream decoder. It pulls bytes from a stream on a valid/ready handshake and turns them into single decoded bits on request. The surrounding decompressor keeps every probability table and symbol tree. It hands the decoder one request at a time and waits for the matching result pulse.

A request comes in one of two modes. In the adaptive mode the caller supplies an 11-bit probability that the next bit is zero. The block returns the decoded bit together with the adapted probability, which the caller writes back to its table. In the equiprobable mode the caller asks for 1 to 26 bits that each carry no model. The block returns them packed into one value, first decoded bit in the most significant position.

The stream starts with a five-byte header that loads the code register, and its first byte must be zero. While decoding, the 32-bit range is kept at or above 2^24. Whenever it falls below, one byte is pulled in before the next decision. The block stalls when no byte is on offer. A flag reports when the code register has reached zero, which a cleanly ended stream leaves behind.

Top module: `rc_bit_decoder`

## Requirements
- R1: After reset, in_ready is 1, req_ready is 0, done is 0, data_err is 0 and finished is 0. The range register holds all ones and the code register holds zero.
- R2: While the header is being read, in_ready is 1 and req_ready is 0. Each accepted header byte is shifted into the low end of the code register. req_ready becomes 1 only after the fifth header byte.
- R3: If the first header byte is not 8'h00, data_err becomes 1 and stays 1 until reset. Once it is set, in_ready and req_ready are both 0 and no further byte is taken.
- R4: Before each bit decision, if range is below 2^24, one byte is accepted. Range and code both shift left by 8, with the byte placed in the low 8 bits of code. This check repeats until range is at least 2^24. Across a whole stream, every byte the encoder emitted is taken, and no others.
- R5: With req_direct=0, bound = (range >> 11) * prob. The bit is 0 when code < bound, and range then becomes bound. Otherwise the bit is 1, and both range and code drop by bound. The bit is returned on done_bit.
- R6: The probability returned on done_prob is prob + ((2048 - prob) >> 5) after a 0 bit, and prob - (prob >> 5) after a 1 bit.
- R7: With req_direct=1 and req_count=N (1 to 26), N bits are decoded. For each bit, range is halved and the halved range is subtracted from code. A negative result gives a 0 bit and leaves code unchanged; a non-negative result gives a 1 bit and keeps the difference. done_value holds the bits with the first decoded bit at position N-1, and every higher bit is 0.
- R8: finished is 1 exactly when the header is complete, no error is set and the code register is zero.
- R9: If a byte is needed and in_valid is 0, in_ready stays 1, no state changes, and decoding resumes with the same step once a byte arrives.
- R10: req_ready is 1 only while the block is idle. Each accepted request produces exactly one done pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_byte | input | 8 | Compressed stream byte |
| in_valid | input | 1 | in_byte is valid |
| in_ready | output | 1 | Block takes in_byte this cycle if in_valid |
| req_valid | input | 1 | Decode request present |
| req_direct | input | 1 | 1 = equiprobable mode, 0 = adaptive mode |
| req_prob | input | 11 | Probability of a zero bit (adaptive mode) |
| req_count | input | 5 | Number of equiprobable bits, 1 to 26 |
| req_ready | output | 1 | Block is idle and accepts a request |
| done | output | 1 | One-cycle result pulse |
| done_bit | output | 1 | Last decoded bit |
| done_prob | output | 11 | Adapted probability (0 in equiprobable mode) |
| done_value | output | 26 | Packed equiprobable bits (0 in adaptive mode) |
| data_err | output | 1 | Sticky header error |
| finished | output | 1 | Code register is zero after the header |

## Verification
An adaptive request accepted at a clock edge yields done two edges later. Each byte pulled for renormalisation adds one edge, and each stalled cycle adds one more. An equiprobable request of N bits needs N+1 edges plus the same byte and stall cycles. The bench does not predict these latencies. It holds each expected result in a queue, waits for the done pulse, samples the outputs at the falling edge and pairs each pulse with the oldest queued item. A second stream with gaps in the byte supply exercises the stall path, and a per-pulse check confirms that done never lasts two cycles.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
  localparam int RCD_RANGE_W    = 32;
  localparam int RCD_PROB_W     = 11;
  localparam int RCD_MOVE_W     = 5;
  localparam int RCD_TOP_BITS   = 24;
  localparam int RCD_INIT_BYTES = 5;
  localparam int RCD_DIRECT_MAX = 26;

  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_IDLE = 2'd1,
    ST_STEP = 2'd2,
    ST_ERR  = 2'd3
  } rcd_state_e;
endpackage

// File: rtl/rcd_refill.sv
// Renormalisation: detects a low range and forms the shifted registers.
module rcd_refill #(
  parameter int RW       = 32,
  parameter int TOP_BITS = 24
) (
  input  logic [RW-1:0] rng_i,
  input  logic [RW-1:0] code_i,
  input  logic [7:0]    byte_i,
  output logic          need_o,
  output logic [RW-1:0] rng_o,
  output logic [RW-1:0] code_o
);
  localparam logic [RW-1:0] TOP_VAL = {{(RW-1){1'b0}}, 1'b1} << TOP_BITS;

  assign need_o = (rng_i < TOP_VAL);
  assign rng_o  = {rng_i[RW-9:0], 8'h00};
  assign code_o = {code_i[RW-9:0], byte_i};
endmodule

// File: rtl/rcd_prob_unit.sv
// One adaptive decision: split point, bit, new range/code and probability.
module rcd_prob_unit #(
  parameter int RW = 32,
  parameter int PW = 11,
  parameter int MV = 5
) (
  input  logic [RW-1:0] rng_i,
  input  logic [RW-1:0] code_i,
  input  logic [PW-1:0] prob_i,
  output logic [RW-1:0] bound_o,
  output logic          bit_o,
  output logic [RW-1:0] rng_o,
  output logic [RW-1:0] code_o,
  output logic [PW-1:0] prob_o
);
  function automatic logic [RW-1:0] split_point(input logic [RW-1:0] r,
                                                input logic [PW-1:0] p);
    logic [RW-1:0] pe;
    pe = {{(RW-PW){1'b0}}, p};
    return (r >> PW) * pe;
  endfunction

  function automatic logic [PW-1:0] adapt(input logic [PW-1:0] p, input logic b);
    logic [PW:0] full;
    logic [PW:0] gap;
    logic [PW:0] inc;
    full = {1'b1, {PW{1'b0}}};
    gap  = full - {1'b0, p};
    inc  = gap >> MV;
    if (b) return p - (p >> MV);
    else   return p + inc[PW-1:0];
  endfunction

  assign bound_o = split_point(rng_i, prob_i);
  assign bit_o   = (code_i >= bound_o);
  assign rng_o   = bit_o ? (rng_i - bound_o) : bound_o;
  assign code_o  = bit_o ? (code_i - bound_o) : code_i;
  assign prob_o  = adapt(prob_i, bit_o);
endmodule

// File: rtl/rcd_direct_unit.sv
// One equiprobable decision using the sign of code - range/2.
module rcd_direct_unit #(
  parameter int RW = 32
) (
  input  logic [RW-1:0] rng_i,
  input  logic [RW-1:0] code_i,
  output logic          bit_o,
  output logic [RW-1:0] rng_o,
  output logic [RW-1:0] code_o
);
  function automatic logic [RW-1:0] trial(input logic [RW-1:0] c,
                                          input logic [RW-1:0] h);
    return c - h;
  endfunction

  logic [RW-1:0] diff;

  assign rng_o  = rng_i >> 1;
  assign diff   = trial(code_i, rng_o);
  assign bit_o  = ~diff[RW-1];
  assign code_o = bit_o ? diff : code_i;
endmodule

// File: rtl/rc_bit_decoder.sv
module rc_bit_decoder
  import rcd_pkg::*;
#(
  parameter int RANGE_W    = RCD_RANGE_W,
  parameter int PROB_W     = RCD_PROB_W,
  parameter int MOVE_W     = RCD_MOVE_W,
  parameter int TOP_BITS   = RCD_TOP_BITS,
  parameter int INIT_BYTES = RCD_INIT_BYTES,
  parameter int DIRECT_MAX = RCD_DIRECT_MAX,
  localparam int CNT_W     = $clog2(DIRECT_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [7:0]            in_byte,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  req_valid,
  input  logic                  req_direct,
  input  logic [PROB_W-1:0]     req_prob,
  input  logic [CNT_W-1:0]      req_count,
  output logic                  req_ready,
  output logic                  done,
  output logic                  done_bit,
  output logic [PROB_W-1:0]     done_prob,
  output logic [DIRECT_MAX-1:0] done_value,
  output logic                  data_err,
  output logic                  finished
);
  localparam int INIT_W = $clog2(INIT_BYTES + 1);

  rcd_state_e              st_q;
  logic [RANGE_W-1:0]      rng_q, code_q;
  logic [INIT_W-1:0]       init_left_q;
  logic                    mode_q;
  logic [PROB_W-1:0]       prob_q;
  logic [CNT_W-1:0]        left_q;
  logic [DIRECT_MAX-1:0]   acc_q;
  logic                    done_q, bit_q, err_q;
  logic [PROB_W-1:0]       pout_q;

  // Named internal events (also used by the bound checker).
  logic               need;
  logic [RANGE_W-1:0] rng_sh, code_sh;
  logic               pbit, dbit;
  logic [RANGE_W-1:0] bound, prng, pcode, drng, dcode;
  logic [PROB_W-1:0]  pprob;
  logic               init_fire, init_first, stall_w, step_fire, norm_fire, last_step;
  logic               step_bit;
  logic [RANGE_W-1:0] step_rng, step_code;

  rcd_refill #(.RW(RANGE_W), .TOP_BITS(TOP_BITS)) u_refill (
    .rng_i(rng_q), .code_i(code_q), .byte_i(in_byte),
    .need_o(need), .rng_o(rng_sh), .code_o(code_sh)
  );

  rcd_prob_unit #(.RW(RANGE_W), .PW(PROB_W), .MV(MOVE_W)) u_prob (
    .rng_i(rng_q), .code_i(code_q), .prob_i(prob_q),
    .bound_o(bound), .bit_o(pbit), .rng_o(prng), .code_o(pcode), .prob_o(pprob)
  );

  rcd_direct_unit #(.RW(RANGE_W)) u_direct (
    .rng_i(rng_q), .code_i(code_q),
    .bit_o(dbit), .rng_o(drng), .code_o(dcode)
  );

  assign init_fire  = (st_q == ST_INIT) && in_valid;
  assign init_first = (init_left_q == INIT_W'(INIT_BYTES));
  assign stall_w    = (st_q == ST_STEP) && need && !in_valid;
  assign norm_fire  = (st_q == ST_STEP) && need && in_valid;
  assign step_fire  = (st_q == ST_STEP) && !need;
  assign last_step  = !mode_q || (left_q <= CNT_W'(1));
  assign step_bit   = mode_q ? dbit  : pbit;
  assign step_rng   = mode_q ? drng  : prng;
  assign step_code  = mode_q ? dcode : pcode;

  assign in_ready   = (st_q == ST_INIT) || ((st_q == ST_STEP) && need);
  assign req_ready  = (st_q == ST_IDLE);
  assign done       = done_q;
  assign done_bit   = bit_q;
  assign done_prob  = pout_q;
  assign done_value = acc_q;
  assign data_err   = err_q;
  assign finished   = ((st_q == ST_IDLE) || (st_q == ST_STEP)) && (code_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_INIT;
      rng_q       <= '1;
      code_q      <= '0;
      init_left_q <= INIT_W'(INIT_BYTES);
      mode_q      <= 1'b0;
      prob_q      <= '0;
      left_q      <= '0;
      acc_q       <= '0;
      done_q      <= 1'b0;
      bit_q       <= 1'b0;
      pout_q      <= '0;
      err_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_INIT: begin
          if (init_fire) begin
            if (init_first && (in_byte != 8'h00)) begin
              err_q <= 1'b1;
              st_q  <= ST_ERR;
            end else begin
              code_q      <= code_sh;
              init_left_q <= init_left_q - INIT_W'(1);
              if (init_left_q == INIT_W'(1)) st_q <= ST_IDLE;
            end
          end
        end
        ST_IDLE: begin
          if (req_valid) begin
            mode_q <= req_direct;
            prob_q <= req_prob;
            left_q <= req_count;
            acc_q  <= '0;
            st_q   <= ST_STEP;
          end
        end
        ST_STEP: begin
          if (norm_fire) begin
            rng_q  <= rng_sh;
            code_q <= code_sh;
          end else if (step_fire) begin
            rng_q  <= step_rng;
            code_q <= step_code;
            if (mode_q) begin
              acc_q  <= {acc_q[DIRECT_MAX-2:0], dbit};
              left_q <= left_q - CNT_W'(1);
            end
            if (last_step) begin
              done_q <= 1'b1;
              bit_q  <= step_bit;
              pout_q <= mode_q ? '0 : pprob;
              st_q   <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rc_bit_decoder_chk.sv
module rc_bit_decoder_chk #(
  parameter int RW       = 32,
  parameter int TOP_BITS = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    in_byte,
  input logic          in_ready,
  input logic          req_ready,
  input logic          done,
  input logic          data_err,
  input logic          init_fire,
  input logic          init_first,
  input logic          stall_w,
  input logic          step_fire,
  input logic          mode_q,
  input logic          pbit,
  input logic [RW-1:0] bound,
  input logic [RW-1:0] rng_q,
  input logic [RW-1:0] code_q
);
  localparam logic [RW-1:0] TOP_VAL = {{(RW-1){1'b0}}, 1'b1} << TOP_BITS;

  p_err_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_err) |-> $past(init_fire && init_first && (in_byte != 8'h00)));

  p_step_normed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |-> (rng_q >= TOP_VAL));

  p_zero_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !mode_q && !pbit) |=> (rng_q == $past(bound)));

  p_direct_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && mode_q) |=> (rng_q == ($past(rng_q) >> 1)));

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall_w |=> ($stable(rng_q) && $stable(code_q)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_no_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !in_ready);
endmodule

bind rc_bit_decoder rc_bit_decoder_chk #(.RW(RANGE_W), .TOP_BITS(TOP_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_ready(in_ready),
  .req_ready(req_ready), .done(done), .data_err(data_err),
  .init_fire(init_fire), .init_first(init_first), .stall_w(stall_w),
  .step_fire(step_fire), .mode_q(mode_q), .pbit(pbit), .bound(bound),
  .rng_q(rng_q), .code_q(code_q)
);

// File: tb/rc_bit_decoder_tb_top.sv
`timescale 1ns/1ps
module rc_bit_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        req_valid = 1'b0;
  logic        req_direct = 1'b0;
  logic [10:0] req_prob = '0;
  logic [4:0]  req_count = '0;
  logic        req_ready, done, done_bit, data_err, finished;
  logic [10:0] done_prob;
  logic [25:0] done_value;

  always #5 clk = ~clk;

  rc_bit_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
    .in_ready(in_ready), .req_valid(req_valid), .req_direct(req_direct),
    .req_prob(req_prob), .req_count(req_count), .req_ready(req_ready),
    .done(done), .done_bit(done_bit), .done_prob(done_prob),
    .done_value(done_value), .data_err(data_err), .finished(finished)
  );

  typedef struct {
    bit          direct;
    logic [10:0] prob;
    logic [4:0]  cnt;
    bit          ebit;
    logic [10:0] eprob;
    logic [25:0] evalue;
  } item_t;

  item_t      reqs[$];
  item_t      expq[$];
  logic [7:0] stream[$];
  int         fidx = 0;
  bit         feed_en = 1'b0;
  bit         gap_mode = 1'b0;
  int         cyc = 0;
  int         checks = 0;
  int         fails = 0;
  bit         prev_done = 1'b0;

  // Reference encoder state
  longint unsigned elow;
  logic [31:0]     erng;
  logic [31:0]     epre;
  logic [7:0]      ecache;
  int              ecsize;
  logic [31:0]     seed_q;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd_next(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic logic [10:0] model_adapt(input int p, input bit b);
    if (b) return 11'(p - p / 32);
    else   return 11'(p + (2048 - p) / 32);
  endfunction

  task automatic enc_reset();
    elow = 0; erng = 32'hFFFF_FFFF; epre = 32'hFFFF_FFFF;
    ecache = 8'h00; ecsize = 1;
    stream.delete();
  endtask

  task automatic enc_shift_low();
    logic [7:0] temp;
    logic [7:0] carry;
    if (elow < 64'h0000_0000_FF00_0000 || elow >= 64'h0000_0001_0000_0000) begin
      carry = {7'b0, elow[32]};
      temp  = ecache;
      do begin
        stream.push_back(temp + carry);
        temp = 8'hFF;
        ecsize--;
      end while (ecsize != 0);
      ecache = elow[31:24];
    end
    ecsize++;
    elow = (elow & 64'h0000_0000_00FF_FFFF) << 8;
  endtask

  task automatic enc_norm();
    while (erng < 32'h0100_0000) begin
      erng = erng << 8;
      enc_shift_low();
    end
  endtask

  task automatic enc_bit(input int p, input bit b);
    logic [31:0] bnd;
    bnd = (erng >> 11) * 32'(p);
    if (!b) erng = bnd;
    else begin
      elow = elow + 64'(bnd);
      erng = erng - bnd;
    end
    epre = erng;
    enc_norm();
  endtask

  task automatic enc_dbit(input bit b);
    erng = erng >> 1;
    if (b) elow = elow + 64'(erng);
    epre = erng;
    enc_norm();
  endtask

  task automatic push_prob(input int p, input bit b);
    item_t it;
    it.direct = 1'b0; it.prob = 11'(p); it.cnt = 5'd0;
    it.ebit = b; it.eprob = model_adapt(p, b); it.evalue = '0;
    enc_bit(p, b);
    reqs.push_back(it);
  endtask

  task automatic build(input logic [31:0] seed);
    int ctx[4];
    int dlist[5];
    item_t it;
    logic [25:0] v;
    logic [31:0] r;
    bit b;
    enc_reset();
    reqs.delete();
    seed_q = seed;
    dlist = '{1, 26, 13, 7, 20};
    for (int k = 0; k < 4; k++) ctx[k] = 1024;
    for (int i = 0; i < 80; i++) begin
      seed_q = rnd_next(seed_q);
      r = seed_q;
      if (i % 9 == 4) begin
        it.direct = 1'b1; it.prob = '0;
        it.cnt = 5'(dlist[(i / 9) % 5]);
        v = r[25:0] & ((26'd1 << it.cnt) - 26'd1);
        if (it.cnt == 5'd26) v = r[25:0];
        it.ebit = v[0]; it.eprob = '0; it.evalue = v;
        for (int j = int'(it.cnt) - 1; j >= 0; j--) enc_dbit(v[j]);
        reqs.push_back(it);
      end else if (i == 30) begin
        push_prob(2047, 1'b1);      // extreme: tiny range, two refill bytes
      end else if (i == 31) begin
        push_prob(1, 1'b0);         // extreme: tiny range after a zero
      end else begin
        int k;
        k = i % 4;
        b = ((r % 8) < 6) ? bit'(k & 1) : !bit'(k & 1);
        push_prob(ctx[k], b);
        ctx[k] = int'(model_adapt(ctx[k], b));
      end
    end
    // Tail so that no refill is pending after the last decision.
    while (epre < 32'h0100_0000) push_prob(2047, 1'b0);
    for (int j = 0; j < 5; j++) enc_shift_low();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; feed_en = 1'b0; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    fidx = 0;
    expq.delete();
    rst_n = 1'b1;
  endtask

  // Byte feeder
  initial begin
    bit fire;
    forever begin
      @(negedge clk);
      if (feed_en && fidx < stream.size() && (!gap_mode || (cyc % 3) == 0)) begin
        in_valid = 1'b1;
        in_byte  = stream[fidx];
      end else begin
        in_valid = 1'b0;
      end
      fire = in_valid && in_ready && rst_n;
      @(posedge clk);
      if (fire) fidx++;
    end
  end

  // Scoreboard monitor
  initial begin
    item_t e;
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (prev_done) chk(1'b0, "R10", "done wider than one cycle", 1, 0);
        if (expq.size() == 0) begin
          chk(1'b0, "R10", "done without a pending request", 1, 0);
        end else begin
          e = expq.pop_front();
          if (e.direct) begin
            chk(done_value == e.evalue, gap_mode ? "R7 R9" : "R7",
                "direct done_value", done_value, e.evalue);
          end else begin
            chk(done_bit == e.ebit, gap_mode ? "R5 R9" : "R5",
                "done_bit", done_bit, e.ebit);
            chk(done_prob == e.eprob, "R6", "done_prob", done_prob, e.eprob);
            chk(done_value == 26'd0, "R7", "done_value in adaptive mode", done_value, 0);
          end
        end
      end
      prev_done = rst_n && done;
    end
  end

  task automatic drive_all();
    foreach (reqs[i]) begin
      req_direct = reqs[i].direct;
      req_prob   = reqs[i].prob;
      req_count  = reqs[i].cnt;
      req_valid  = 1'b1;
      while (!req_ready) @(negedge clk);
      expq.push_back(reqs[i]);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (i == 0) chk(req_ready == 1'b0, "R10", "req_ready while busy", req_ready, 0);
      while (!done) @(negedge clk);
    end
  endtask

  task automatic run_stream(input logic [31:0] seed, input bit gaps);
    do_reset();
    build(seed);
    gap_mode = gaps;
    feed_en  = 1'b1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    chk(fidx == 5, "R2", "bytes taken when header done", fidx, 5);
    drive_all();
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R10", "results outstanding", expq.size(), 0);
    chk(fidx == stream.size(), "R4", "stream bytes consumed", fidx, stream.size());
    chk(finished == 1'b1, "R8", "finished at clean end", finished, 1);
  endtask

  task automatic header_case(input logic [7:0] b0, input logic [7:0] b4);
    do_reset();
    stream.delete();
    stream.push_back(b0);
    for (int j = 0; j < 3; j++) stream.push_back(8'h00);
    stream.push_back(b4);
    gap_mode = 1'b0;
    feed_en  = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(req_ready == 1'b0, "R1", "req_ready after reset", req_ready, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(data_err == 1'b0, "R1", "data_err after reset", data_err, 0);
    chk(finished == 1'b0, "R1", "finished after reset", finished, 0);

    run_stream(32'h1234_5678, 1'b0);
    run_stream(32'h9E37_79B9, 1'b1);   // R9: starved byte supply

    // R2: four header bytes are not enough
    do_reset();
    stream.delete();
    for (int j = 0; j < 4; j++) stream.push_back(8'h00);
    gap_mode = 1'b0; feed_en = 1'b1;
    repeat (10) @(negedge clk);
    chk(req_ready == 1'b0, "R2", "req_ready after 4 header bytes", req_ready, 0);
    chk(in_ready == 1'b1, "R2", "in_ready after 4 header bytes", in_ready, 1);
    chk(fidx == 4, "R2", "bytes taken", fidx, 4);
    stream.push_back(8'h01);
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R2", "req_ready after 5th byte", req_ready, 1);
    chk(finished == 1'b0, "R8", "finished with code 1", finished, 0);

    header_case(8'h00, 8'h00);
    chk(req_ready == 1'b1, "R2", "req_ready, zero header", req_ready, 1);
    chk(finished == 1'b1, "R8", "finished with code 0", finished, 1);

    header_case(8'h5A, 8'h00);
    chk(data_err == 1'b1, "R3", "data_err on bad first byte", data_err, 1);
    chk(in_ready == 1'b0, "R3", "in_ready after error", in_ready, 0);
    chk(req_ready == 1'b0, "R3", "req_ready after error", req_ready, 0);
    chk(fidx == 1, "R3", "bytes taken after error", fidx, 1);
    chk(finished == 1'b0, "R8", "finished after error", finished, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not complete actual=%0d expected=%0d", cyc, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule